// File: doc/BRIEF.md
# Dual-Mode Timer with Byte-Buffered Register Access

This block is a timer/counter that runs either as an 8-bit counter with a programmable period or as a full 16-bit counter. A single mode input selects the width. The counter advances on a clock-enable tick from an upstream source. A power-of-two prescaler thins the ticks first. Each period match (8-bit mode) or wrap past the top count (16-bit mode) is an event. Every event drives an output pulse, and a postscaler counts events before it raises a sticky interrupt flag.

Software reaches the block through a small register port with four addresses: counter low byte, high byte, control/status, and an unused slot. In 8-bit mode the high-byte register holds the next period. That value reaches the active period only when a match occurs. In 16-bit mode the high byte is reached through a buffer that moves only when the low byte is accessed. A low-byte read snapshots the live high byte, and a low-byte write loads both bytes on the same edge. Software therefore always sees and sets coherent 16-bit values.

Top module: `dual_timer`

## Requirements
- R1: After reset the low counter reads 0x00, the high-byte buffer reads 0xFF, the active period / live high byte is 0xFF, the flag and interrupt enable are 0, and `pulse_o` and `irq_o` are low.
- R2: The counter steps only on a prescaler step. With `pre_sel_i` = n (0..15), a step occurs on every 2^n-th cycle with `tick_i` high. The tick count restarts after each step. With `tick_i` low nothing changes.
- R3: In 8-bit mode (`wide_i` = 0), a step where the low counter equals the active period is an event. The low counter becomes 0x00 and the active period takes the buffer value. On any other step the low counter increments.
- R4: A write to address 1 changes only the high-byte buffer. In 8-bit mode it does not touch the counter or the active period before the next match.
- R5: `pulse_o` is updated on every step to show whether that step was an event. After an event it therefore stays high for exactly one count.
- R6: In 16-bit mode (`wide_i` = 1), the pair {live high, low} increments on each step. A step taken at 0xFFFF wraps to 0x0000 and is an event.
- R7: In 16-bit mode, a read strobe at address 0 copies the live high byte into the buffer. A read of address 1 always returns the buffer.
- R8: In 16-bit mode, a write to address 0 loads the low counter from the write data and the live high byte from the buffer on the same edge.
- R9: With `post_sel_i` = m, the flag is set on every (m+1)-th event.
- R10: The flag is sticky. A write to address 2 with data bit 0 = 0 clears it, and bit 0 = 1 leaves it unchanged. A hardware set in the same cycle wins. Data bit 1 of that write sets the enable. `irq_o` is flag AND enable.
- R11: A write to address 0 or 1 clears the prescaler and postscaler counts, and no step occurs in that cycle.
- R12: `rdata_o` is combinational: address 0 gives the low counter, address 1 the buffer, address 2 {zeros, enable in bit 1, flag in bit 0}, and address 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from upstream |
| wide_i | input | 1 | 0: 8-bit period mode, 1: 16-bit mode |
| pre_sel_i | input | 4 | Prescaler exponent, ratio 2^n |
| post_sel_i | input | 4 | Postscaler, events per flag minus one |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pulse_o | output | 1 | Event pulse, one count long |
| irq_o | output | 1 | Interrupt request |

## Verification
The 8-bit period path is run with a continuous tick and period 3, so the events must come every fourth cycle. It is run again with a 1:4 prescaler, where the pulse must stay high for four cycles per event. This separates per-step pulse holding from per-clock pulse holding. The 16-bit path starts just below the wrap point, which shows that the wrap is what raises the event and the flag. A low/high read pair taken while the counter runs shows that the high byte was frozen by the low-byte read. Writes placed in the middle of a prescaler count and in the middle of a postscaler count show that the counts restart. A behavioural model compared on every clock catches any change in the cycle at which any of this happens.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
    typedef enum logic [1:0] {
        ADDR_LOW  = 2'd0,
        ADDR_HIGH = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } dt_addr_e;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
    parameter int PW = 15,
    parameter int SW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          clr_i,
    input  logic [SW-1:0] sel_i,
    output logic          step_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [SW-1:0] eff_sel;
    logic [PW-1:0] limit;
    logic          term;

    always_comb begin
        eff_sel = (int'(sel_i) > PW) ? SW'(PW) : sel_i;
        limit   = ~({PW{1'b1}} << eff_sel);
        term    = (st_q.cnt == limit);
        step_o  = tick_i && !clr_i && term;
        st_d    = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = term ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/dt_count_core.sv
module dt_count_core #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    input  logic          wide_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic          rd_lo_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] live_o,
    output logic [DW-1:0] buf_o,
    output logic          event_o,
    output logic          pulse_o
);
    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] live;
        logic [DW-1:0] bufh;
        logic          pulse;
    } core_st_t;

    core_st_t      st_d, st_q;
    logic          full, match;
    logic [CW-1:0] next_wide;

    always_comb begin
        full      = &{st_q.live, st_q.lo};
        match     = (st_q.lo == st_q.live);
        next_wide = {st_q.live, st_q.lo} + 1'b1;
        event_o   = step_i && (wide_i ? full : match);
        st_d      = st_q;
        if (step_i) begin
            st_d.pulse = event_o;
            if (wide_i) begin
                {st_d.live, st_d.lo} = next_wide;
            end else if (match) begin
                st_d.lo   = '0;
                st_d.live = st_q.bufh;
            end else begin
                st_d.lo = st_q.lo + 1'b1;
            end
        end
        if (rd_lo_i && wide_i) st_d.bufh = st_q.live;
        if (wr_hi_i)           st_d.bufh = wdata_i;
        if (wr_lo_i) begin
            st_d.lo = wdata_i;
            if (wide_i) st_d.live = st_q.bufh;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lo    <= '0;
            st_q.live  <= '1;
            st_q.bufh  <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_o    = st_q.lo;
    assign live_o  = st_q.live;
    assign buf_o   = st_q.bufh;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/dt_event_flag.sv
module dt_event_flag #(
    parameter int SW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          evt_i,
    input  logic          clr_i,
    input  logic [SW-1:0] sel_i,
    input  logic          ctl_wr_i,
    input  logic [1:0]    ctl_wdata_i,
    output logic          flag_o,
    output logic          en_o
);
    typedef struct packed {
        logic [SW-1:0] post;
        logic          flag;
        logic          en;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     set_flag;

    always_comb begin
        st_d     = st_q;
        set_flag = 1'b0;
        if (clr_i) begin
            st_d.post = '0;
        end else if (evt_i) begin
            if (st_q.post == sel_i) begin
                st_d.post = '0;
                set_flag  = 1'b1;
            end else begin
                st_d.post = st_q.post + 1'b1;
            end
        end
        if (ctl_wr_i) begin
            st_d.flag = st_q.flag & ctl_wdata_i[0];
            st_d.en   = ctl_wdata_i[1];
        end
        if (set_flag) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dual_timer_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 15,
    parameter int SW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wide_i,
    input  logic [SW-1:0] pre_sel_i,
    input  logic [SW-1:0] post_sel_i,
    input  logic [1:0]    addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          pulse_o,
    output logic          irq_o
);
    logic          wr_lo, wr_hi, wr_ctl, rd_lo, cnt_clr, step, evt;
    logic          flag, irq_en;
    logic [DW-1:0] cnt_lo, cnt_live, cnt_buf;

    always_comb begin
        wr_lo   = wr_i && (dt_addr_e'(addr_i) == ADDR_LOW);
        wr_hi   = wr_i && (dt_addr_e'(addr_i) == ADDR_HIGH);
        wr_ctl  = wr_i && (dt_addr_e'(addr_i) == ADDR_CTRL);
        rd_lo   = rd_i && (dt_addr_e'(addr_i) == ADDR_LOW);
        cnt_clr = wr_lo || wr_hi;
    end

    dt_prescaler #(.PW(PW), .SW(SW)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .clr_i  (cnt_clr),
        .sel_i  (pre_sel_i),
        .step_o (step)
    );

    dt_count_core #(.DW(DW)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step),
        .wide_i  (wide_i),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .rd_lo_i (rd_lo),
        .wdata_i (wdata_i),
        .lo_o    (cnt_lo),
        .live_o  (cnt_live),
        .buf_o   (cnt_buf),
        .event_o (evt),
        .pulse_o (pulse_o)
    );

    dt_event_flag #(.SW(SW)) u_flag (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt),
        .clr_i       (cnt_clr),
        .sel_i       (post_sel_i),
        .ctl_wr_i    (wr_ctl),
        .ctl_wdata_i (wdata_i[1:0]),
        .flag_o      (flag),
        .en_o        (irq_en)
    );

    always_comb begin
        case (dt_addr_e'(addr_i))
            ADDR_LOW:  rdata_o = cnt_lo;
            ADDR_HIGH: rdata_o = cnt_buf;
            ADDR_CTRL: rdata_o = {{(DW-2){1'b0}}, irq_en, flag};
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = flag && irq_en;
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic          wide_i,
    input logic [1:0]    addr_i,
    input logic          wr_i,
    input logic          rd_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] lo_i,
    input logic [DW-1:0] live_i,
    input logic [DW-1:0] buf_i,
    input logic          evt_i,
    input logic          flag_i,
    input logic          pulse_i
);
    AST_TICK_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !(wr_i && addr_i[1] == 1'b0)) |=> $stable(lo_i)); // R2

    AST_MATCH_CLEARS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wide_i && evt_i) |=> (lo_i == '0)); // R3

    AST_PULSE_AFTER_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> pulse_i); // R5

    AST_LOW_READ_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wide_i && rd_i && !wr_i && addr_i == 2'd0) |=> (buf_i == $past(live_i))); // R7

    AST_WIDE_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wide_i && wr_i && addr_i == 2'd0) |=> (live_i == $past(buf_i) && lo_i == $past(wdata_i))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !(wr_i && addr_i == 2'd2 && !wdata_i[0])) |=> flag_i); // R10
endmodule

bind dual_timer dt_checker #(.DW(DW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wide_i  (wide_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .lo_i    (cnt_lo),
    .live_i  (cnt_live),
    .buf_i   (cnt_buf),
    .evt_i   (evt),
    .flag_i  (flag),
    .pulse_i (pulse_o)
);

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wide = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [3:0] pre_sel = '0, post_sel = '0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pulse, irq;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_lo = 0, m_live = 255, m_buf = 255, m_pre = 0, m_post = 0;
    int m_flag = 0, m_en = 0, m_out = 0;

    always #2 clk = ~clk;

    dual_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wide_i(wide),
        .pre_sel_i(pre_sel), .post_sel_i(post_sel), .addr_i(addr),
        .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
        .pulse_o(pulse), .irq_o(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_rdata();
        case (addr)
            2'd0:    return m_lo;
            2'd1:    return m_buf;
            2'd2:    return m_en * 2 + m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        int o_lo = m_lo, o_live = m_live, o_buf = m_buf;
        bit wl = wr && addr == 2'd0;
        bit wh = wr && addr == 2'd1;
        bit clr = wl || wh;
        bit term = (m_pre == (1 << pre_sel) - 1);
        bit stp = tick && !clr && term;
        bit ev = 0;
        bit setf = 0;
        if (clr) m_pre = 0;
        else if (tick) m_pre = term ? 0 : m_pre + 1;
        if (stp) begin
            if (wide) ev = (o_live == 255 && o_lo == 255);
            else      ev = (o_lo == o_live);
            m_out = ev;
            if (wide) begin
                int v = (o_live * 256 + o_lo + 1) % 65536;
                m_live = v / 256;
                m_lo = v % 256;
            end else if (ev) begin
                m_lo = 0;
                m_live = o_buf;
            end else begin
                m_lo = o_lo + 1;
            end
        end
        if (rd && addr == 2'd0 && wide) m_buf = o_live;
        if (wh) m_buf = wdata;
        if (wl) begin
            m_lo = wdata;
            if (wide) m_live = o_buf;
        end
        if (clr) m_post = 0;
        else if (ev) begin
            if (m_post == post_sel) begin
                m_post = 0;
                setf = 1;
            end else m_post++;
        end
        if (wr && addr == 2'd2) begin
            m_flag = m_flag & wdata[0];
            m_en = wdata[1];
        end
        if (setf) m_flag = 1;
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_edge();
        #1;
        chk("R5 pulse", pulse, m_out);
        chk("R10 irq", irq, m_flag & m_en);
        chk("R12 rdata", rdata, m_rdata());
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        addr = a; rd = 1'b1;
        #1;
        v = rdata;
        cyc();
        rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, hi_cnt, lo_before;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd_reg(2'd0, v); chk("R1 low", v, 0);
        rd_reg(2'd1, v); chk("R1 buffer", v, 255);
        rd_reg(2'd2, v); chk("R1 status", v, 0);
        chk("R1 pulse", pulse, 0);
        chk("R1 irq", irq, 0);

        // R3: 8-bit period 3, continuous tick
        wr_reg(2'd1, 8'd3);
        tick = 1'b1;
        wr_reg(2'd0, 8'd255);
        hi_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cyc();
            if (pulse) hi_cnt++;
        end
        chk("R3 events in 40 cycles", hi_cnt, 10);

        // R4: high write leaves counter untouched
        tick = 1'b0;
        rd_reg(2'd0, lo_before);
        wr_reg(2'd1, 8'd5);
        rd_reg(2'd0, v); chk("R4 low unchanged", v, lo_before);
        rd_reg(2'd1, v); chk("R4 buffer written", v, 5);

        // R2 / R5: prescaler 1:4, period 3
        wr_reg(2'd1, 8'd3);
        pre_sel = 4'd2;
        tick = 1'b1;
        wr_reg(2'd0, 8'(m_live));
        repeat (3) cyc();
        hi_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            cyc();
            if (pulse) hi_cnt++;
        end
        chk("R2 R5 pulse cycles at 1:4", hi_cnt, 16);
        tick = 1'b0;
        rd_reg(2'd0, lo_before);
        repeat (10) cyc();
        rd_reg(2'd0, v); chk("R2 tick low holds", v, lo_before);

        // R9: postscaler 1:3
        pre_sel = 4'd0;
        post_sel = 4'd2;
        wr_reg(2'd2, 8'd2);
        wr_reg(2'd0, 8'(m_live));
        tick = 1'b1;
        repeat (8) cyc();
        chk("R9 no flag after two events", irq, 0);
        cyc();
        chk("R9 flag on third event", irq, 1);

        // R10: sticky flag
        tick = 1'b0;
        wr_reg(2'd2, 8'd3); chk("R10 write one keeps flag", irq, 1);
        wr_reg(2'd2, 8'd2); chk("R10 write zero clears", irq, 0);
        wr_reg(2'd2, 8'd1);
        rd_reg(2'd2, v); chk("R10 one does not set", v, 0);

        // R8 / R6: 16-bit wrap
        wide = 1'b1;
        post_sel = 4'd0;
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'hFE);
        rd_reg(2'd0, v); chk("R8 low loaded", v, 8'hFE);
        rd_reg(2'd1, v); chk("R8 high loaded", v, 8'hFF);
        wr_reg(2'd2, 8'd2);
        tick = 1'b1;
        repeat (2) cyc();
        tick = 1'b0;
        chk("R6 wrap event pulse", pulse, 1);
        chk("R6 wrap raises irq", irq, 1);
        rd_reg(2'd0, v); chk("R6 low wrapped", v, 0);
        rd_reg(2'd1, v); chk("R6 high wrapped", v, 0);

        // R7: coherent read while running
        wr_reg(2'd1, 8'h12);
        wr_reg(2'd0, 8'h34);
        tick = 1'b1;
        rd_reg(2'd0, v); chk("R7 low snapshot", v, 8'h34);
        repeat (3) cyc();
        rd_reg(2'd1, v); chk("R7 high from snapshot", v, 8'h12);
        tick = 1'b0;

        // R11: write clears the prescaler count
        wide = 1'b0;
        pre_sel = 4'd3;
        tick = 1'b1;
        repeat (5) cyc();
        wr_reg(2'd0, 8'd0);
        repeat (7) cyc();
        rd_reg(2'd0, v); chk("R11 no step before eighth tick", v, 0);
        addr = 2'd0;
        #1;
        chk("R11 step on eighth tick", rdata, (m_live == 0) ? 0 : 1);
        tick = 1'b0;

        // R12: unused address
        rd_reg(2'd3, v); chk("R12 spare address", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule